// File: doc/BRIEF.md
# Sequential Miss Stream Trainer

This block sits beside a level-one data cache and looks at every miss the cache reports. Each miss carries a line address and a flag that marks it as a store (clear means load). The block decides when a run of misses forms a unit-stride sequence, in either the ascending or the descending direction. When it finds one, it asks a downstream prefetch engine to open a new stream.

Two small candidate tables do the training. The ascending table predicts the line just above a miss. The descending table predicts the line just below it. Each entry holds a predicted line and a hit count. A miss that matches a prediction moves that prediction one line further in the same direction. When the entry has seen a software-set number of misses, including the miss that created it, the block emits a single-cycle allocation and frees the entry. A miss that matches nothing in either table seeds one entry in each table. The entry it replaces is chosen by that table's own round-robin pointer.

Top module: `miss_stream_trainer`

## Requirements
- R1: After a synchronous reset, `alloc_valid` is 0 and both tables are empty, so no miss can match a prediction until new misses have trained the tables.
- R2: Misses at lines L, L+1, ..., L+N-1 with effective threshold N produce an allocation one cycle after the last of them, with `alloc_line` = L+N (the line after the last miss) and `alloc_desc` = 0.
- R3: Misses at lines L, L-1, ..., L-N+1 produce an allocation one cycle after the last of them, with `alloc_line` = L-N and `alloc_desc` = 1.
- R4: `alloc_store` copies the `miss_store` flag (1 = store, 0 = load) of the miss that completed the training.
- R5: The effective threshold is `train_thresh`, except that the values 0 and 1 are treated as 2. An allocation happens on exactly the miss that brings the entry's count to this threshold. A seeded entry starts with a count of 1.
- R6: The entry that causes an allocation is invalidated. A later miss at the line that entry would have predicted next causes no allocation.
- R7: The ascending table is searched first. A miss that matches in both tables trains only the ascending entry and leaves the descending entry unchanged. Within one table, the matching entry with the lowest index is used.
- R8: A miss that matches in neither table writes the entry at each table's round-robin pointer and advances that pointer. After DEPTH further seeding misses, the oldest seeded candidate is lost.
- R9: `alloc_valid` is a single-cycle pulse. It is raised only in the cycle after an accepted miss (`miss_valid` = 1). When `miss_valid` is 0, the tables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A cache miss is present this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_store | input | 1 | 1 = store miss, 0 = load miss |
| train_thresh | input | CNT_W | Misses needed to allocate (0 and 1 act as 2) |
| alloc_valid | output | 1 | One-cycle request to open a stream |
| alloc_line | output | LINE_W | First line the new stream should fetch |
| alloc_desc | output | 1 | 1 = descending stream, 0 = ascending |
| alloc_store | output | 1 | Request type of the stream |

## Verification
The only results at the ports are the allocation outputs. They are registered once, so the outputs for a miss presented before a rising edge are due right after that edge. The bench drives each miss on a falling edge and compares all four outputs on the next falling edge against a behavioural model. That model advances in the same step, so every comparison lands exactly one cycle after its stimulus. Scenario-level counts of allocations, with hand-computed lines, confirm that the model itself is exercised along the requirements.

// File: rtl/mst_pkg.sv
package mst_pkg;

    // Smallest effective training threshold.
    localparam int unsigned MIN_THRESH = 2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    function automatic logic [31:0] clamp_thresh(input logic [31:0] raw);
        return (raw < MIN_THRESH) ? 32'(MIN_THRESH) : raw;
    endfunction

endpackage

// File: rtl/mst_filter.sv
module mst_filter
    import mst_pkg::*;
#(
    parameter int unsigned LINE_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CNT_W  = 4,
    parameter dir_e        DIR    = DIR_UP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] look_line,
    input  logic [CNT_W-1:0]  thresh_eff,
    input  logic              do_train,
    input  logic              do_fill,
    output logic              hit,
    output logic              promote
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][LINE_W-1:0] pred;
        logic [DEPTH-1:0][CNT_W-1:0]  cnt;
        logic [PTR_W-1:0]             ptr;
    } tbl_t;

    tbl_t s_d, s_q;

    logic [DEPTH-1:0] match_vec;
    logic [PTR_W-1:0] hit_idx;
    logic [CNT_W-1:0] cnt_inc;
    logic [LINE_W-1:0] step_line;

    always_comb begin
        step_line = (DIR == DIR_DOWN) ? (look_line - LINE_W'(1))
                                      : (look_line + LINE_W'(1));
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match_vec[g] = s_q.vld[g] && (s_q.pred[g] == look_line);
    end

    // Lowest matching index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = PTR_W'(i);
        end
    end

    assign hit     = |match_vec;
    assign cnt_inc = s_q.cnt[hit_idx] + CNT_W'(1);
    assign promote = hit && (cnt_inc >= thresh_eff);

    always_comb begin
        s_d = s_q;
        if (do_train && hit) begin
            if (promote) begin
                s_d.vld[hit_idx] = 1'b0;
                s_d.cnt[hit_idx] = '0;
            end else begin
                s_d.pred[hit_idx] = step_line;
                s_d.cnt[hit_idx]  = cnt_inc;
            end
        end
        if (do_fill) begin
            s_d.vld[s_q.ptr]  = 1'b1;
            s_d.pred[s_q.ptr] = step_line;
            s_d.cnt[s_q.ptr]  = CNT_W'(1);
            s_d.ptr           = (s_q.ptr == LAST) ? '0 : s_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R7: training is only requested for a table that matched
    p_train_on_hit_r7: assert property (@(posedge clk) disable iff (rst)
        do_train |-> hit);

    // R6: a promoted entry is gone in the next cycle
    p_promote_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (do_train && promote && !do_fill) |=> (s_q.vld[$past(hit_idx)] == 1'b0));

endmodule

// File: rtl/mst_alloc_out.sv
module mst_alloc_out #(
    parameter int unsigned LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [LINE_W-1:0] line,
    input  logic              desc,
    input  logic              store,
    output logic              alloc_valid,
    output logic [LINE_W-1:0] alloc_line,
    output logic              alloc_desc,
    output logic              alloc_store
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic              desc;
        logic              store;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.vld   = fire;
        if (fire) begin
            o_d.line  = line;
            o_d.desc  = desc;
            o_d.store = store;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign alloc_valid = o_q.vld;
    assign alloc_line  = o_q.line;
    assign alloc_desc  = o_q.desc;
    assign alloc_store = o_q.store;

endmodule

// File: rtl/miss_stream_trainer.sv
module miss_stream_trainer
    import mst_pkg::*;
#(
    parameter int unsigned LINE_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic              miss_store,
    input  logic [CNT_W-1:0]  train_thresh,
    output logic              alloc_valid,
    output logic [LINE_W-1:0] alloc_line,
    output logic              alloc_desc,
    output logic              alloc_store
);
    logic [CNT_W-1:0] thresh_eff;
    logic up_hit, up_prom, dn_hit, dn_prom;
    logic up_train, dn_train, fill;
    logic fire, fire_desc;
    logic [LINE_W-1:0] fire_line;

    assign thresh_eff = CNT_W'(clamp_thresh(32'(train_thresh)));

    assign up_train = miss_valid && up_hit;
    assign dn_train = miss_valid && !up_hit && dn_hit;
    assign fill     = miss_valid && !up_hit && !dn_hit;

    mst_filter #(.LINE_W(LINE_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DIR(DIR_UP)) u_up (
        .clk(clk), .rst(rst), .look_line(miss_line), .thresh_eff(thresh_eff),
        .do_train(up_train), .do_fill(fill), .hit(up_hit), .promote(up_prom));

    mst_filter #(.LINE_W(LINE_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DIR(DIR_DOWN)) u_dn (
        .clk(clk), .rst(rst), .look_line(miss_line), .thresh_eff(thresh_eff),
        .do_train(dn_train), .do_fill(fill), .hit(dn_hit), .promote(dn_prom));

    always_comb begin
        fire      = (up_train && up_prom) || (dn_train && dn_prom);
        fire_desc = !(up_train && up_prom);
        fire_line = fire_desc ? (miss_line - LINE_W'(1)) : (miss_line + LINE_W'(1));
    end

    mst_alloc_out #(.LINE_W(LINE_W)) u_out (
        .clk(clk), .rst(rst), .fire(fire), .line(fire_line), .desc(fire_desc),
        .store(miss_store), .alloc_valid(alloc_valid), .alloc_line(alloc_line),
        .alloc_desc(alloc_desc), .alloc_store(alloc_store));

    // R9: an allocation only follows an accepted miss
    p_pulse_after_miss_r9: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> $past(miss_valid));

    // R2: ascending allocation starts one line above the last miss
    p_up_line_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_desc) |-> (alloc_line == $past(miss_line) + LINE_W'(1)));

    // R3: descending allocation starts one line below the last miss
    p_dn_line_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_desc) |-> (alloc_line == $past(miss_line) - LINE_W'(1)));

    // R4: type follows the completing miss
    p_type_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> (alloc_store == $past(miss_store)));

endmodule

// File: tb/miss_stream_trainer_tb_top.sv
module miss_stream_trainer_tb_top;
    localparam int LW = 32;
    localparam int DP = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0;
    logic [LW-1:0] miss_line = '0;
    logic miss_store = 1'b0;
    logic [CW-1:0] train_thresh = 4'd2;
    logic alloc_valid, alloc_desc, alloc_store;
    logic [LW-1:0] alloc_line;

    always #2 clk = ~clk;

    miss_stream_trainer #(.LINE_W(LW), .DEPTH(DP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_store(miss_store), .train_thresh(train_thresh),
        .alloc_valid(alloc_valid), .alloc_line(alloc_line),
        .alloc_desc(alloc_desc), .alloc_store(alloc_store));

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // behavioural model state
    bit          m_up_v [DP];
    int unsigned m_up_p [DP];
    int          m_up_c [DP];
    int          m_up_r;
    bit          m_dn_v [DP];
    int unsigned m_dn_p [DP];
    int          m_dn_c [DP];
    int          m_dn_r;
    bit          e_v, e_d, e_s;
    int unsigned e_l;
    int          seen_allocs;
    int unsigned last_line;
    bit          last_desc, last_store;

    task automatic model_reset();
        for (int i = 0; i < DP; i++) begin
            m_up_v[i] = 0; m_up_p[i] = 0; m_up_c[i] = 0;
            m_dn_v[i] = 0; m_dn_p[i] = 0; m_dn_c[i] = 0;
        end
        m_up_r = 0; m_dn_r = 0;
        e_v = 0; e_d = 0; e_s = 0; e_l = 0;
    endtask

    task automatic model_step(input bit v, input int unsigned ln, input bit st, input int th);
        int thr;
        int ui, di;
        thr = (th < 2) ? 2 : th;
        e_v = 0;
        if (!v) return;
        ui = -1; di = -1;
        for (int i = DP - 1; i >= 0; i--) begin
            if (m_up_v[i] && m_up_p[i] == ln) ui = i;
            if (m_dn_v[i] && m_dn_p[i] == ln) di = i;
        end
        if (ui >= 0) begin
            if (m_up_c[ui] + 1 >= thr) begin
                m_up_v[ui] = 0; m_up_c[ui] = 0;
                e_v = 1; e_d = 0; e_s = st; e_l = ln + 1;
            end else begin
                m_up_c[ui]++; m_up_p[ui] = ln + 1;
            end
        end else if (di >= 0) begin
            if (m_dn_c[di] + 1 >= thr) begin
                m_dn_v[di] = 0; m_dn_c[di] = 0;
                e_v = 1; e_d = 1; e_s = st; e_l = ln - 1;
            end else begin
                m_dn_c[di]++; m_dn_p[di] = ln - 1;
            end
        end else begin
            m_up_v[m_up_r] = 1; m_up_p[m_up_r] = ln + 1; m_up_c[m_up_r] = 1;
            m_up_r = (m_up_r + 1) % DP;
            m_dn_v[m_dn_r] = 1; m_dn_p[m_dn_r] = ln - 1; m_dn_c[m_dn_r] = 1;
            m_dn_r = (m_dn_r + 1) % DP;
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (alloc_valid !== e_v ||
            (e_v && (alloc_line !== e_l || alloc_desc !== e_d || alloc_store !== e_s))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b line=%0d desc=%0b st=%0b exp v=%0b line=%0d desc=%0b st=%0b",
                     tag, alloc_valid, alloc_line, alloc_desc, alloc_store, e_v, e_l, e_d, e_s);
        end
        if (alloc_valid === 1'b1) begin
            seen_allocs++;
            last_line = alloc_line; last_desc = alloc_desc; last_store = alloc_store;
        end
    endtask

    // one cycle: check result of previous cycle, then drive and predict
    task automatic cyc(input bit v, input int unsigned ln, input bit st);
        @(negedge clk);
        compare();
        miss_valid = v; miss_line = ln; miss_store = st;
        model_step(v, ln, st, int'(train_thresh));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    task automatic check(input bit ok, input string what, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_one(input int unsigned ln, input bit dsc, input bit st);
        check(seen_allocs == 1, "alloc count", seen_allocs, 1);
        check(last_line == ln, "alloc line", last_line, ln);
        check(last_desc == dsc, "alloc dir", last_desc, dsc);
        check(last_store == st, "alloc type", last_store, st);
        seen_allocs = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        seen_allocs = 0; last_line = 0; last_desc = 0; last_store = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        check(alloc_valid == 1'b0, "alloc after reset", alloc_valid, 0);
        idle(3);
        check(seen_allocs == 0, "no alloc when idle", seen_allocs, 0);

        // R2: ascending, threshold 3
        tag = "R2"; train_thresh = 4'd3;
        cyc(1, 100, 0); cyc(1, 101, 0); cyc(1, 102, 0); idle(2);
        expect_one(103, 0, 0);

        // R3 / R4: descending store stream
        tag = "R3";
        cyc(1, 500, 1); cyc(1, 499, 1); cyc(1, 498, 1); idle(2);
        tag = "R4";
        expect_one(497, 1, 1);

        // R5: threshold 0 behaves as 2
        tag = "R5"; train_thresh = 4'd0;
        cyc(1, 900, 0); cyc(1, 901, 0); idle(2);
        expect_one(902, 0, 0);

        // R6: stream entry released after allocation
        tag = "R6";
        cyc(1, 902, 0); idle(2);
        check(seen_allocs == 0, "no alloc after release", seen_allocs, 0);

        // R7: both tables match, ascending wins, descending untouched
        tag = "R7"; train_thresh = 4'd2;
        cyc(1, 2000, 0); cyc(1, 2002, 0); cyc(1, 2001, 0); idle(2);
        expect_one(2002, 0, 0);
        cyc(1, 2001, 1); idle(2);
        expect_one(2000, 1, 1);

        // R8: round-robin replacement loses the oldest candidate
        tag = "R8";
        cyc(1, 3000, 0); cyc(1, 4000, 0); cyc(1, 5000, 0); cyc(1, 6000, 0); cyc(1, 7000, 0);
        cyc(1, 3001, 0); idle(2);
        check(seen_allocs == 0, "evicted candidate", seen_allocs, 0);
        cyc(1, 7001, 0); idle(2);
        expect_one(7002, 0, 0);

        // R9: matching line without valid does nothing
        tag = "R9";
        cyc(1, 8000, 0); cyc(0, 8001, 0); idle(2);
        check(seen_allocs == 0, "invalid miss ignored", seen_allocs, 0);
        cyc(1, 8001, 0); idle(3);
        expect_one(8002, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule